// File: doc/BRIEF.md
# Predicated-execution condition sequencer

This block follows a run of up to four conditionally executed compact instructions that an if-then instruction opens. The if-then instruction hands over an 8-bit state byte; from then on, each retired instruction moves the state one slot forward. For the slot now current, the block compares the 4-bit condition against the N, Z, C and V flags and says whether that instruction executes or is skipped. When no run is open, every instruction executes.

Next to this, the block reads the first 16-bit halfword of an instruction and reports whether the instruction is 32 bits long. That check is purely combinational. Fetch, decode beyond length, and the logic that produces the flags are outside the block.

Top module: `cond_seq`

## Requirements
- R1: A synchronous active-high reset clears the state byte. After reset, `in_block` is 0, `cur_cond` is 0 and `exec_ok` is 1.
- R2: When `ld_en` is high at a clock edge, the state byte takes `ld_state`. `cur_cond` then shows bits 7:4 of the state and `in_block` shows whether bits 3:0 are nonzero.
- R3: With `retire` high and `ld_en` low, an advance keeps state bits 7:5. It replaces bits 4:0 with bits 3:0 followed by a zero.
- R4: If an advance leaves state bits 3:0 all zero, the whole state byte becomes zero and the run ends.
- R5: If `ld_en` and `retire` are both high in one cycle, the load wins and no advance happens.
- R6: With both `ld_en` and `retire` low, the state byte holds its value.
- R7: While `in_block` is 0, `exec_ok` is 1 whatever the flags are.
- R8: Inside a run, conditions 0 to 7 test a single flag. The flags port `nzcv` carries N on bit 3, Z on bit 2, C on bit 1 and V on bit 0. Codes 0 and 1 are true for Z set and Z clear. Codes 2 and 3 are true for C set and C clear. Codes 4 and 5 are true for N set and N clear. Codes 6 and 7 are true for V set and V clear.
- R9: Inside a run, conditions 8 to 13 combine flags:
  - code 8 is true for C set and Z clear, and code 9 is its complement;
  - code 10 is true for N equal to V, and code 11 for N differing from V;
  - code 12 is true for Z clear and N equal to V, and code 13 is its complement.
- R10: Inside a run, condition codes 14 and 15 are always true.
- R11: `wide_insn` is 1 exactly when `halfword[15:13]` is 3'b111 and `halfword[12:11]` is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load the state byte from an if-then instruction |
| ld_state | input | 8 | State byte to load |
| retire | input | 1 | An instruction retired; advance the state |
| halfword | input | 16 | First halfword of the instruction being sized |
| nzcv | input | 4 | Flags N, Z, C, V on bits 3 to 0 |
| in_block | output | 1 | A conditional run is open |
| cur_cond | output | 4 | Condition of the current slot |
| exec_ok | output | 1 | The current instruction executes |
| wide_insn | output | 1 | The halfword starts a 32-bit instruction |

## Verification
Several behaviours are checked by the assertions on every cycle:
- reset clearing the state;
- load contents and load priority;
- holding while idle;
- preservation of the upper condition bits on an advance;
- clearing when the mask empties;
- unconditional execution outside a run and for codes 14 and 15;
- the short-instruction forms of the length check.

The full sixteen-way condition table against every flag combination, the shift pattern of the mask across a four-slot run, and the exact length result for arbitrary halfwords are shown only by the bench. The bench compares random and directed scenarios against its own model of the state byte.

// File: rtl/cond_seq.sv
module cond_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_en,
  input  logic [7:0]  ld_state,
  input  logic        retire,
  input  logic [15:0] halfword,
  input  logic [3:0]  nzcv,
  output logic        in_block,
  output logic [3:0]  cur_cond,
  output logic        exec_ok,
  output logic        wide_insn
);

  logic [7:0] state;
  logic [7:0] adv;
  logic       pass;

  assign adv = {state[7:5], state[3:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst)
      state <= 8'h00;
    else if (ld_en)
      state <= ld_state;
    else if (retire)
      state <= (adv[3:0] == 4'h0) ? 8'h00 : adv;
  end

  function automatic logic eval_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'h0: eval_cond = z;
      4'h1: eval_cond = !z;
      4'h2: eval_cond = cy;
      4'h3: eval_cond = !cy;
      4'h4: eval_cond = n;
      4'h5: eval_cond = !n;
      4'h6: eval_cond = v;
      4'h7: eval_cond = !v;
      4'h8: eval_cond = cy && !z;
      4'h9: eval_cond = !cy || z;
      4'hA: eval_cond = (n == v);
      4'hB: eval_cond = (n != v);
      4'hC: eval_cond = !z && (n == v);
      4'hD: eval_cond = z || (n != v);
      default: eval_cond = 1'b1;
    endcase
  endfunction

  assign pass      = eval_cond(state[7:4], nzcv);
  assign in_block  = |state[3:0];
  assign cur_cond  = state[7:4];
  assign exec_ok   = in_block ? pass : 1'b1;
  assign wide_insn = (halfword[15:13] == 3'b111) && (halfword[12:11] != 2'b00);

endmodule

module cond_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        ld_en,
  input logic [7:0]  ld_state,
  input logic        retire,
  input logic [15:0] halfword,
  input logic [7:0]  state,
  input logic        in_block,
  input logic [3:0]  cur_cond,
  input logic        exec_ok,
  input logic        wide_insn
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (state == 8'h00 && exec_ok && !in_block));

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !retire) |=> (cur_cond == $past(ld_state[7:4]) && in_block == $past(|ld_state[3:0])));

  assert_keep_top_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && retire && state[2:0] != 3'b000) |=> (cur_cond[3:1] == $past(cur_cond[3:1])));

  assert_block_end_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && retire && state[2:0] == 3'b000) |=> (state == 8'h00));

  assert_load_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (ld_en && retire) |=> (state == $past(ld_state)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld_en && !retire) |=> $stable(state));

  assert_free_exec_R7: assert property (@(posedge clk) disable iff (rst)
    !in_block |-> exec_ok);

  assert_always_true_R10: assert property (@(posedge clk) disable iff (rst)
    (in_block && cur_cond[3:1] == 3'b111) |-> exec_ok);

  assert_short_len_R11: assert property (@(posedge clk) disable iff (rst)
    (halfword[15:13] != 3'b111 || halfword[12:11] == 2'b00) |-> !wide_insn);

endmodule

bind cond_seq cond_seq_chk u_chk (
  .clk(clk), .rst(rst), .ld_en(ld_en), .ld_state(ld_state), .retire(retire),
  .halfword(halfword), .state(state), .in_block(in_block), .cur_cond(cur_cond),
  .exec_ok(exec_ok), .wide_insn(wide_insn)
);

// File: tb/cond_seq_bench.sv
`timescale 1ns/1ps
module cond_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en;
  logic [7:0]  ld_state;
  logic        retire;
  logic [15:0] halfword;
  logic [3:0]  nzcv;
  logic        in_block, exec_ok, wide_insn;
  logic [3:0]  cur_cond;

  int total = 0;
  int bad = 0;
  logic [7:0] m_state;
  string st_tag = "R1";

  always #2 clk = ~clk;

  cond_seq u_cond_seq (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_state(ld_state), .retire(retire),
    .halfword(halfword), .nzcv(nzcv), .in_block(in_block), .cur_cond(cur_cond),
    .exec_ok(exec_ok), .wide_insn(wide_insn)
  );

  function automatic logic ref_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    if (c >= 4'd14) return 1'b1;
    case (c)
      0: return z;          1: return !z;
      2: return cy;         3: return !cy;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return cy & ~z;    9: return ~(cy & ~z);
      10: return n == v;    11: return n != v;
      12: return ~z & (n == v);
      default: return ~(~z & (n == v));
    endcase
  endfunction

  function automatic logic ref_wide(input logic [15:0] h);
    return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
  endfunction

  function automatic logic [7:0] ref_next(input logic [7:0] s, input logic l,
                                           input logic [7:0] ls, input logic r);
    logic [7:0] a;
    if (l) return ls;
    if (!r) return s;
    a = {s[7:5], s[3:0], 1'b0};
    return (a[3:0] == 4'h0) ? 8'h00 : a;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_now();
    logic ib;
    string et;
    ib = |m_state[3:0];
    chk({st_tag, " cur_cond"}, {4'h0, cur_cond}, {4'h0, m_state[7:4]});
    chk({st_tag, " in_block"}, {7'h0, in_block}, {7'h0, ib});
    if (!ib) et = "R7";
    else if (m_state[7:4] < 4'd8) et = "R8";
    else if (m_state[7:4] < 4'd14) et = "R9";
    else et = "R10";
    chk({et, " exec_ok"}, {7'h0, exec_ok}, {7'h0, ib ? ref_cond(m_state[7:4], nzcv) : 1'b1});
    chk("R11 wide_insn", {7'h0, wide_insn}, {7'h0, ref_wide(halfword)});
  endtask

  task automatic cyc(input logic l, input logic [7:0] ls, input logic r,
                     input logic [15:0] h, input logic [3:0] f);
    ld_en = l; ld_state = ls; retire = r; halfword = h; nzcv = f;
    #1;
    check_now();
    @(posedge clk);
    if (l && r) st_tag = "R5";
    else if (l) st_tag = "R2";
    else if (r) st_tag = (ref_next(m_state, 1'b0, 8'h0, 1'b1) == 8'h00) ? "R4" : "R3";
    else st_tag = "R6";
    m_state = ref_next(m_state, l, ls, r);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst = 1'b1; ld_en = 0; ld_state = 0; retire = 0; halfword = 0; nzcv = 0;
    m_state = 8'h00;
    @(posedge clk); @(negedge clk);
    chk("R1 in_block", {7'h0, in_block}, 8'h00);
    chk("R1 cur_cond", {4'h0, cur_cond}, 8'h00);
    chk("R1 exec_ok", {7'h0, exec_ok}, 8'h01);
    rst = 1'b0;
    st_tag = "R1";
    for (int f = 0; f < 16; f++) cyc(0, 0, 0, 16'h0000, f[3:0]);
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++) begin
        cyc(1, {c[3:0], 4'b1000}, 0, 16'h4700, f[3:0]);
        cyc(0, 0, 0, 16'hE000, f[3:0]);
      end
    cyc(1, 8'h08, 0, 16'hE800, 4'h4);
    cyc(0, 0, 1, 16'hF000, 4'h4);
    cyc(0, 0, 0, 16'hF800, 4'h0);
    cyc(1, 8'hFF, 0, 16'hD000, 4'h0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, 16'hE7FF, 4'hA);
    cyc(1, 8'h3C, 0, 16'h0000, 4'h0);
    cyc(1, 8'h92, 1, 16'hFFFF, 4'h0);
    cyc(0, 0, 0, 16'h1234, 4'h0);
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 8) == 0, 8'($urandom), $urandom % 2, 16'($urandom), 4'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule